// File: doc/BRIEF.md
# Self-Monitoring Serial Transmitter for a Shared Line

This block sends asynchronous serial frames onto a single wire that other nodes also drive. While a frame is on the wire, it compares the level it drives on its transmit output with the level it reads back on its receive input. A mismatch at the chosen sampling moment sets a collision flag. The flag stays set until software clears it.

Three configuration inputs shape the behaviour. The first picks the sampling moment: either the baud tick, or a strobe from an external one-shot timer. The second lets a collision drop the transmit enable on its own, which aborts the frame in progress. The third picks how a frame starts: either on the first baud tick after the enable is set, or on a qualifying edge seen on the receive line. A polarity input inverts the received level. Frames carry nine data bits. The receiver path and the timer are outside this block.

Top module: `coll_uart_tx`

## Requirements
- R1: A frame on txd_o is a 0 start bit, then data bits D0 to D8 with the least significant bit first, then a 1 stop bit. Each bit is held for exactly one baud-tick period. The line is 1 whenever no frame is in progress.
- R2: With start_sel_i=0 and the enable set, an idle transmitter starts the start bit in the cycle after the next baud tick. busy_o goes to 1 in that same cycle. While the enable stays set, frames follow one another with one idle tick period between them. With the enable at 0, no frame starts.
- R3: With start_sel_i=1, baud ticks never start a frame. A qualifying receive edge makes busy_o=1 and txd_o=0 in the next cycle.
- R4: The received level is rxd_i XOR rx_pol_i. The qualifying edge is a 1-to-0 change of that level, which is a falling rxd_i when rx_pol_i=0 and a rising rxd_i when rx_pol_i=1. A change in the other direction is ignored. Collisions are judged on that same level.
- R5: A qualifying edge is ignored when the enable is not already 1 in the cycle of the edge. This includes an edge in the same cycle as the en_set_i pulse.
- R6: With samp_sel_i=0, during a frame the driven bit is compared with the received level only in cycles where tick_i=1. A mismatch makes coll_o=1 in the next cycle. A mismatch in a cycle without a tick has no effect.
- R7: With samp_sel_i=1, the comparison happens only in cycles where tmr_uf_i=1. tick_i plays no part in it.
- R8: coll_o stays 1 until a coll_clr_i pulse arrives. If a clear pulse and a new mismatch fall in the same cycle, coll_o stays 1.
- R9: With auto_clr_i=1, a collision clears tx_en_o in the same cycle that coll_o becomes 1. With auto_clr_i=0, a collision leaves tx_en_o unchanged.
- R10: If the enable is 0 while a frame is in progress, whether through en_clr_i or through an automatic clear, then at the next baud tick the frame is aborted: busy_o goes to 0 and txd_o goes to 1 in the following cycle.
- R11: After reset, txd_o=1, busy_o=0, coll_o=0 and tx_en_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick, one cycle wide |
| tmr_uf_i | input | 1 | Underflow strobe from the external one-shot timer |
| data_i | input | DATA_W | Data word, captured when a frame starts |
| en_set_i | input | 1 | Pulse that sets the transmit enable |
| en_clr_i | input | 1 | Pulse that clears the transmit enable |
| coll_clr_i | input | 1 | Pulse that clears the collision flag |
| samp_sel_i | input | 1 | Sampling moment: 0 = baud tick, 1 = timer strobe |
| auto_clr_i | input | 1 | 1 = a collision clears the enable |
| start_sel_i | input | 1 | Frame start: 0 = next tick, 1 = receive edge |
| rx_pol_i | input | 1 | 1 = invert the received level |
| rxd_i | input | 1 | Level read back from the shared line |
| txd_o | output | 1 | Transmit line |
| busy_o | output | 1 | A frame is in progress |
| coll_o | output | 1 | Sticky collision flag |
| tx_en_o | output | 1 | Current transmit enable |

## Verification
The assertions rely on a few properties of the inputs. en_set_i and en_clr_i are never pulsed together. rx_pol_i and start_sel_i change only while the transmitter is idle. The bench keeps to these rules by writing configuration only between frames. The one exception is a deliberate change of samp_sel_i in the middle of a frame. That change is safe because the sampling moment matters only in a cycle when it is used. The read-back line is modelled as a loopback of txd_o through the polarity bit. Collisions come from a one-cycle inversion placed on chosen tick and non-tick cycles, and edges come from driving the line directly while the transmitter is idle.

// File: rtl/coll_uart_pkg.sv
package coll_uart_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/cu_rx_edge.sv
module cu_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic fall_o
);
  logic prev_q;

  assign lvl_o  = rxd_i ^ pol_i;
  assign fall_o = prev_q & ~lvl_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_o;
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R4
endmodule

// File: rtl/cu_coll_mon.sv
module cu_coll_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tmr_uf_i,
  input  logic samp_sel_i,
  input  logic busy_i,
  input  logic txd_i,
  input  logic rx_lvl_i,
  input  logic auto_clr_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic coll_clr_i,
  output logic coll_o,
  output logic en_o
);
  logic strobe, hit, coll_q, en_q;

  assign strobe = samp_sel_i ? tmr_uf_i : tick_i;
  assign hit    = busy_i & strobe & (txd_i != rx_lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      coll_q <= hit | (coll_q & ~coll_clr_i);
      if (en_clr_i || (hit && auto_clr_i)) en_q <= 1'b0;
      else if (en_set_i)                   en_q <= 1'b1;
    end
  end

  assign coll_o = coll_q;
  assign en_o   = en_q;

  AST_COLL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_q && !coll_clr_i) |=> coll_q); // R8
  AST_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && auto_clr_i) |=> (!en_q && coll_q)); // R9
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !coll_clr_i) |=> $stable(coll_q)); // R6
endmodule

// File: rtl/cu_tx_frame.sv
module cu_tx_frame
  import coll_uart_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              edge_mode_i,
  input  logic              rx_fall_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  tx_state_e          st_q;
  logic [FRAME_W-1:0] frm_q;
  logic [CNT_W-1:0]   idx_q;
  logic               txd_q, start;

  assign start = (st_q == ST_IDLE) & en_i & (edge_mode_i ? rx_fall_i : tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      frm_q <= '1;
      idx_q <= '0;
      txd_q <= 1'b1;
    end else if (st_q == ST_IDLE) begin
      if (start) begin
        st_q  <= ST_SEND;
        frm_q <= {1'b1, data_i, 1'b0};
        idx_q <= '0;
        txd_q <= 1'b0;
      end
    end else if (tick_i) begin
      if (!en_i || idx_q == LAST) begin
        st_q  <= ST_IDLE;
        txd_q <= 1'b1;
      end else begin
        frm_q <= {1'b1, frm_q[FRAME_W-1:1]};
        idx_q <= idx_q + 1'b1;
        txd_q <= frm_q[1];
      end
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = (st_q == ST_SEND);

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> txd_q); // R1
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_q); // R1
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && !tick_i) |=> $stable(txd_q)); // R1
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && tick_i && !en_i) |=> (st_q == ST_IDLE)); // R10
  AST_NO_START_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !en_i) |=> (st_q == ST_IDLE)); // R5
endmodule

// File: rtl/coll_uart_tx.sv
module coll_uart_tx #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tmr_uf_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              coll_clr_i,
  input  logic              samp_sel_i,
  input  logic              auto_clr_i,
  input  logic              start_sel_i,
  input  logic              rx_pol_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              coll_o,
  output logic              tx_en_o
);
  logic rx_lvl, rx_fall, en, txd, busy;

  cu_rx_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rxd_i (rxd_i),
    .pol_i (rx_pol_i),
    .lvl_o (rx_lvl),
    .fall_o(rx_fall)
  );

  cu_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en),
    .edge_mode_i(start_sel_i),
    .rx_fall_i  (rx_fall),
    .data_i     (data_i),
    .txd_o      (txd),
    .busy_o     (busy)
  );

  cu_coll_mon u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .tmr_uf_i  (tmr_uf_i),
    .samp_sel_i(samp_sel_i),
    .busy_i    (busy),
    .txd_i     (txd),
    .rx_lvl_i  (rx_lvl),
    .auto_clr_i(auto_clr_i),
    .en_set_i  (en_set_i),
    .en_clr_i  (en_clr_i),
    .coll_clr_i(coll_clr_i),
    .coll_o    (coll_o),
    .en_o      (en)
  );

  assign txd_o   = txd;
  assign busy_o  = busy;
  assign tx_en_o = en;

  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tx_en_o)); // R5
endmodule

// File: tb/coll_uart_tx_tb_top.sv
module coll_uart_tx_tb_top;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 9;
  localparam int TICK_P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, uf = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic en_set = 0, en_clr = 0, coll_clr = 0;
  logic samp = 0, auto_c = 0, ssel = 0, pol = 0;
  logic inject = 0, force_mode = 0, force_lvl = 1;
  logic rxd, txd, busy, coll, en;
  int   n_chk = 0, n_bad = 0, tcnt = 0;
  logic tick_run = 0;

  always #(CLK_P/2) clk = ~clk;

  assign rxd = force_mode ? (force_lvl ^ pol) : (txd ^ pol ^ inject);

  always @(negedge clk) begin
    if (tick_run) begin
      tcnt <= (tcnt == TICK_P-1) ? 0 : tcnt + 1;
      tick <= (tcnt == TICK_P-2);
    end else tick <= 1'b0;
  end

  coll_uart_tx #(.DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tmr_uf_i(uf), .data_i(data),
    .en_set_i(en_set), .en_clr_i(en_clr), .coll_clr_i(coll_clr),
    .samp_sel_i(samp), .auto_clr_i(auto_c), .start_sel_i(ssel), .rx_pol_i(pol),
    .rxd_i(rxd), .txd_o(txd), .busy_o(busy), .coll_o(coll), .tx_en_o(en)
  );

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_set();  en_set = 1; step(); en_set = 0; endtask
  task automatic pulse_clr();  en_clr = 1; step(); en_clr = 0; endtask
  task automatic pulse_cclr(); coll_clr = 1; step(); coll_clr = 0; endtask

  task automatic wait_busy();
    for (int i = 0; i < 100 && !busy; i++) step();
  endtask

  task automatic wait_new_frame();
    for (int i = 0; i < 100 && busy; i++) step();
    for (int i = 0; i < 100 && !busy; i++) step();
  endtask

  task automatic wait_tick(input logic lvl);
    for (int i = 0; i < 20 && tick != lvl; i++) step();
  endtask

  // current step shows the first cycle with busy=1
  task automatic check_frame(input logic [DATA_W-1:0] d);
    for (int b = 0; b <= DATA_W + 1; b++) begin
      logic exp_b, ok;
      exp_b = (b == 0) ? 1'b0 : (b == DATA_W + 1) ? 1'b1 : d[b-1];
      ok = 1'b1;
      for (int s = 0; s < TICK_P; s++) begin
        if (!(b == 0 && s == 0)) step();
        if (txd !== exp_b || busy !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R1 frame bit", int'(txd), int'(exp_b));
    end
    step();
    chk(!busy && txd, "R1 idle after stop", int'({busy, txd}), 1);
  endtask

  function automatic logic [DATA_W-1:0] pat(input int k);
    case (k)
      0: pat = '0;
      1: pat = '1;
      2: pat = 9'h155;
      3: pat = 9'h0AA;
      default: pat = DATA_W'(1) << (k - 4);
    endcase
  endfunction

  initial begin
    repeat (3) step();
    // R11 reset state
    chk(txd === 1'b1, "R11 txd", int'(txd), 1);
    chk(busy === 1'b0 && coll === 1'b0 && en === 1'b0, "R11 flags",
        int'({busy, coll, en}), 0);
    rst_n = 1; tick_run = 1;
    repeat (4) step();

    // R1/R2: frame sweep over polarity and sampling moment, tick start
    for (int cfg = 0; cfg < 4; cfg++) begin
      pol = cfg[0]; samp = cfg[1]; ssel = 0;
      data = pat(0);
      pulse_set();
      wait_busy();
      for (int k = 0; k < DATA_W + 4; k++) begin
        int gap;
        check_frame(data);
        if (k == DATA_W + 3) begin
          pulse_clr();
          break;
        end
        data = pat(k + 1);
        gap = 0;
        while (!busy && gap < 20) begin step(); gap++; end
        chk(gap == TICK_P, "R2 idle gap", gap, TICK_P);
      end
      repeat (8) step();
      chk(!busy, "R2 no start with enable off", int'(busy), 0);
      chk(!coll, "R6 no collision on loopback", int'(coll), 0);
    end

    // R3/R4/R5: edge start
    for (int p = 0; p < 2; p++) begin
      pol = p[0]; ssel = 1; samp = 0; auto_c = 0;
      force_mode = 1; force_lvl = 1;
      repeat (3) step();
      force_lvl = 0; step(); repeat (3) step();
      chk(!busy, "R5 edge while disabled", int'(busy), 0);
      force_lvl = 1; step();
      en_set = 1; force_lvl = 0; step(); en_set = 0;
      repeat (6) step();
      chk(!busy && en, "R5 edge same cycle as enable", int'(busy), 0);
      chk(!busy, "R3 ticks do not start", int'(busy), 0);
      force_lvl = 1; step(); repeat (2) step();
      chk(!busy, "R4 wrong edge direction", int'(busy), 0);
      force_lvl = 0; step();
      chk(busy && !txd, "R3 start on edge", int'({busy, txd}), 2);
      force_mode = 0;
      for (int i = 0; i < 100 && busy; i++) step();
      chk(!busy && !coll, "R4 edge frame clean", int'({busy, coll}), 0);
      repeat (10) step();
      chk(!busy, "R3 one frame per edge", int'(busy), 0);
      pulse_clr();
    end

    // R6/R7/R8: collision detection
    pol = 0; ssel = 0; samp = 0; auto_c = 0; data = 9'h0C3;
    pulse_set();
    wait_busy();
    wait_tick(1'b0);
    inject = 1; step(); inject = 0;
    chk(!coll, "R6 mismatch off tick ignored", int'(coll), 0);
    wait_tick(1'b1);
    inject = 1; step(); inject = 0;
    chk(coll, "R6 mismatch on tick", int'(coll), 1);
    chk(en, "R9 enable kept without auto clear", int'(en), 1);
    repeat (5) step();
    chk(coll, "R8 flag sticky", int'(coll), 1);
    pulse_cclr();
    chk(!coll, "R8 clear pulse", int'(coll), 0);
    wait_tick(1'b1);
    inject = 1; coll_clr = 1; step(); inject = 0; coll_clr = 0;
    chk(coll, "R8 clear and hit same cycle", int'(coll), 1);
    pulse_cclr();

    wait_new_frame();
    samp = 1;
    wait_tick(1'b1);
    inject = 1; step(); inject = 0;
    chk(!coll, "R7 tick ignored in timer mode", int'(coll), 0);
    wait_tick(1'b0);
    inject = 1; uf = 1; step(); inject = 0; uf = 0;
    chk(coll, "R7 timer strobe samples", int'(coll), 1);
    pulse_cclr();
    wait_tick(1'b0);
    uf = 1; step(); uf = 0;
    chk(!coll, "R7 strobe with match", int'(coll), 0);

    // R9/R10: auto clear and abort
    samp = 0; auto_c = 1;
    wait_new_frame();
    wait_tick(1'b1);
    inject = 1; step(); inject = 0;
    chk(coll && !en, "R9 auto clear same cycle", int'({coll, en}), 2);
    chk(busy, "R10 frame runs until tick", int'(busy), 1);
    wait_tick(1'b1);
    step();
    chk(!busy && txd, "R10 abort at tick", int'({busy, txd}), 1);
    repeat (10) step();
    chk(!busy, "R10 stays idle", int'(busy), 0);
    pulse_cclr();

    auto_c = 0;
    pulse_set();
    wait_busy();
    repeat (6) step();
    pulse_clr();
    chk(!en && busy, "R10 software clear mid frame", int'({en, busy}), 1);
    wait_tick(1'b1);
    step();
    chk(!busy && txd, "R10 abort after software clear", int'({busy, txd}), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule